// File: doc/BRIEF.md
# Clock-Crossing First-Word-Fall-Through Sample Queue

This block carries data words from a slow producer clock domain into a fast consumer clock domain. A typical use is passing converter samples from a 20 MHz acquisition controller to a processing pipeline on a faster clock. The producer raises a one-cycle store strobe with a word. The consumer sees the oldest stored word already on its data output, qualified by a presence flag. It acknowledges the word to move on to the next one.

Each side runs on its own clock and has its own reset. The producer pointer and the consumer pointer each cross to the other side in Gray code through a two-stage synchronizer. The full flag is derived on the producer side and the presence flag on the consumer side. The storage depth is the requested minimum, raised to at least three and then rounded up to a power of two.

Top module: `xdom_fwft_fifo`

## Requirements
- R1: While both resets are active, and after both are released with nothing written, `wr_full` and `rd_valid` are low. Asserting both resets discards any stored words.
- R2: A write clock edge with `wr_put` high and `wr_full` low stores `wr_data`.
- R3: A `wr_put` while `wr_full` is high is dropped. The dropped word never appears on `rd_data`, and the stored words are left intact.
- R4: When at least one word is stored, `rd_valid` goes high and the oldest word is on `rd_data` with no request. While `rd_got` is low, `rd_data` holds steady.
- R5: A read clock edge with `rd_got` and `rd_valid` both high consumes the word. After that edge `rd_data` shows the next word, or `rd_valid` is low if the queue is now empty.
- R6: `rd_got` while `rd_valid` is low has no effect. A later word is still delivered intact, and only once.
- R7: Words leave in exactly the order they were stored.
- R8: The capacity is the smallest power of two that is at least max(MIN_DEPTH, 3). With the defaults it is 4. `wr_full` rises right after the write edge that stores the 4th unread word, and it is low after the 3rd.
- R9: Once words are consumed, `wr_full` falls within 5 write clock cycles.
- R10: With one store every 16 write cycles of a 20 MHz clock, and a read clock running faster than the write clock that consumes every presented word, `wr_full` never rises and no word is lost.
- R11: Each Gray-coded pointer changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Producer-side reset, active high, asynchronous assertion |
| wr_put | input | 1 | Store strobe for `wr_data` |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot; stores are dropped |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Consumer-side reset, active high, asynchronous assertion |
| rd_got | input | 1 | Acknowledge that the word on `rd_data` was taken |
| rd_valid | output | 1 | At least one word is stored and shown |
| rd_data | output | DATA_W | Oldest stored word |

## Verification
A producer pointer that advances while full shows up as an overwritten word. On the consumer side this appears as a wrong value within a few read cycles of the drain, and the fill-and-overflow case is built to expose it. A consumer pointer that moves on an acknowledge without a word skips a sample, so the next `rd_data` compare after the following store fails. A broken full comparison in the Gray domain shows as `wr_full` asserting one word early or late, or never falling after a drain. Both are sampled on the write clock cycle right after the edge that matters.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

    // Smallest power of two not below max(min_words, 3).
    function automatic int unsigned fifo_depth(input int unsigned min_words);
        int unsigned need;
        int unsigned d;
        need = (min_words < 3) ? 3 : min_words;
        d = 1;
        while (d < need) d = d * 2;
        return d;
    endfunction

    function automatic int unsigned fifo_addr_w(input int unsigned min_words);
        return $clog2(fifo_depth(min_words));
    endfunction

endpackage

// File: rtl/xdom_sync2.sv
module xdom_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_out = st_q.sync;
endmodule

// File: rtl/xdom_store.sv
module xdom_store #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 2
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    // Read is combinational so the head word falls through with no request.
    assign rdata = cells_q[raddr];
endmodule

// File: rtl/xdom_wr_side.sv
module xdom_wr_side #(
    parameter int ADDR_W = 2,
    localparam int PW = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put,
    input  logic [PW-1:0]     rd_gray_sync,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PW-1:0]     wr_gray,
    output logic              full
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      accept;
    logic [PW-1:0] far_mark;

    // A full queue has a write pointer equal to the read pointer with the top two Gray bits flipped.
    assign far_mark = {~rd_gray_sync[PW-1:PW-2], rd_gray_sync[PW-3:0]};

    always_comb begin
        accept    = put && !st_q.full;
        st_d.bin  = st_q.bin + PW'(accept);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        st_d.full = (st_d.gray == far_mark);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign we      = accept;
    assign waddr   = st_q.bin[ADDR_W-1:0];
    assign wr_gray = st_q.gray;
    assign full    = st_q.full;
endmodule

// File: rtl/xdom_rd_side.sv
module xdom_rd_side #(
    parameter int ADDR_W = 2,
    localparam int PW = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              got,
    input  logic [PW-1:0]     wr_gray_sync,
    output logic [ADDR_W-1:0] raddr,
    output logic [PW-1:0]     rd_gray,
    output logic              valid
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      present;
    logic      take;

    always_comb begin
        present   = (st_q.gray != wr_gray_sync);
        take      = got && present;
        st_d.bin  = st_q.bin + PW'(take);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign raddr   = st_q.bin[ADDR_W-1:0];
    assign rd_gray = st_q.gray;
    assign valid   = present;
endmodule

// File: rtl/xdom_fwft_fifo.sv
module xdom_fwft_fifo #(
    parameter int DATA_W    = 12,
    parameter int MIN_DEPTH = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_put,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_got,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ADDR_W = xdom_fifo_pkg::fifo_addr_w(MIN_DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  wr_gray_in_rd;
    logic [PTR_W-1:0]  rd_gray_in_wr;

    xdom_wr_side #(.ADDR_W(ADDR_W)) i_wr (
        .clk(wr_clk), .rst(wr_rst), .put(wr_put), .rd_gray_sync(rd_gray_in_wr),
        .we(we), .waddr(waddr), .wr_gray(wr_gray), .full(wr_full)
    );

    xdom_rd_side #(.ADDR_W(ADDR_W)) i_rd (
        .clk(rd_clk), .rst(rd_rst), .got(rd_got), .wr_gray_sync(wr_gray_in_rd),
        .raddr(raddr), .rd_gray(rd_gray), .valid(rd_valid)
    );

    xdom_sync2 #(.W(PTR_W)) i_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .async_in(wr_gray), .sync_out(wr_gray_in_rd)
    );

    xdom_sync2 #(.W(PTR_W)) i_sync_r2w (
        .clk(wr_clk), .rst(wr_rst), .async_in(rd_gray), .sync_out(rd_gray_in_wr)
    );

    xdom_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/xdom_fwft_fifo_chk.sv
module xdom_fwft_fifo_chk #(
    parameter int DATA_W = 12,
    parameter int PTR_W  = 3
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_full,
    input logic [PTR_W-1:0]  wr_gray,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_got,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  rd_gray
);
    // R3: a full queue takes no word at the next write edge
    assert_full_blocks_store_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_full |=> $stable(wr_gray));

    // R4: the shown word holds while it is not acknowledged
    assert_head_steady_R4: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        (rd_valid && !rd_got) |=> $stable(rd_data));

    // R6: an acknowledge with nothing shown leaves the read pointer alone
    assert_idle_got_ignored_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_valid |=> $stable(rd_gray));

    // R11: Gray pointers move one bit at a time
    assert_wr_gray_step_R11: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    assert_rd_gray_step_R11: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind xdom_fwft_fifo xdom_fwft_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_full(wr_full), .wr_gray(wr_gray),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_got(rd_got), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_gray(rd_gray)
);

// File: tb/test_xdom_fwft_fifo.sv
`timescale 1ns/1ps
module test_xdom_fwft_fifo;
    localparam int DW = 12;
    localparam int NV = 16;
    localparam logic [DW-1:0] VEC [NV] = '{
        12'h000, 12'hFFF, 12'hA5A, 12'h5A5, 12'h001, 12'h800, 12'h7FF, 12'h123,
        12'h456, 12'h789, 12'hABC, 12'hDEF, 12'h0F0, 12'hF0F, 12'h3C3, 12'hC3C};

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1;
    logic wr_put = 0, rd_got = 0;
    logic [DW-1:0] wr_data = '0;
    logic wr_full, rd_valid;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] exp_q [$];
    bit pace_on = 0, full_seen = 0, done = 0;

    always #25 wr_clk = ~wr_clk;   // 20 MHz producer
    always #4  rd_clk = ~rd_clk;   // 125 MHz consumer

    xdom_fwft_fifo #(.DATA_W(DW), .MIN_DEPTH(3)) i_xdom_fwft_fifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_put(wr_put), .wr_data(wr_data), .wr_full(wr_full),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_got(rd_got), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [DW-1:0] d);
        @(negedge wr_clk); wr_put = 1; wr_data = d;
        @(negedge wr_clk); wr_put = 0;
    endtask

    // Consume n words, comparing each against the reference queue (R5, R7).
    task automatic read_words(input int n, input string req);
        int got_n = 0;
        int idle = 0;
        while (got_n < n && idle < 2000) begin
            @(negedge rd_clk);
            rd_got = 0;
            if (rd_valid) begin
                logic [DW-1:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
                chk(rd_data === e, req, 32'(rd_data), 32'(e));
                rd_got = 1;
                got_n++;
                idle = 0;
            end else idle++;
        end
        if (got_n < n) chk(0, req, got_n, n);
        @(negedge rd_clk); rd_got = 0;
    endtask

    always @(negedge wr_clk) if (pace_on && wr_full) full_seen = 1;

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge wr_clk);
        chk(!wr_full && !rd_valid, "R1 in reset", {wr_full, rd_valid}, 0);
        wr_rst = 0; rd_rst = 0;
        repeat (3) @(negedge wr_clk);
        chk(!wr_full && !rd_valid, "R1 after reset", {wr_full, rd_valid}, 0);

        // R10, R7, R2: paced stream from the vector table, one store per 16 write cycles
        pace_on = 1;
        fork
            begin
                for (int i = 0; i < NV; i++) begin
                    exp_q.push_back(VEC[i]);
                    put_word(VEC[i]);
                    repeat (14) @(negedge wr_clk);
                end
            end
            read_words(NV, "R10 R7 paced word");
        join
        pace_on = 0;
        chk(!full_seen, "R10 full never rose", full_seen, 0);

        // R8: fill with the consumer stalled
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back(DW'(12'h100 + k));
            put_word(DW'(12'h100 + k));
            if (k == 2) chk(!wr_full, "R8 not full after 3", wr_full, 0);
        end
        chk(wr_full, "R8 full after 4", wr_full, 1);

        // R3: store attempt while full is dropped
        put_word(12'hDEA);
        chk(wr_full, "R3 still full", wr_full, 1);
        read_words(4, "R3 R7 stored words intact");
        chk(!rd_valid, "R5 valid drops when empty", rd_valid, 0);
        repeat (5) @(negedge wr_clk);
        chk(!wr_full, "R9 full clears", wr_full, 0);

        // R6: acknowledge with nothing shown
        @(negedge rd_clk); rd_got = 1;
        repeat (10) @(negedge rd_clk);
        chk(!rd_valid, "R6 still empty", rd_valid, 0);
        rd_got = 0;
        exp_q.push_back(12'h3C5);
        put_word(12'h3C5);
        repeat (4) @(negedge rd_clk);
        // R4: head word falls through with no request and holds
        chk(rd_valid && rd_data == 12'h3C5, "R4 head shown", 32'(rd_data), 32'h3C5);
        repeat (3) @(negedge rd_clk);
        chk(rd_valid && rd_data == 12'h3C5, "R4 head steady", 32'(rd_data), 32'h3C5);
        read_words(1, "R6 word after idle got");
        chk(!rd_valid, "R6 delivered once", rd_valid, 0);

        // R1: both resets discard stored words
        put_word(12'h0AA);
        put_word(12'h0BB);
        repeat (4) @(negedge rd_clk);
        chk(rd_valid, "R1 data before reset", rd_valid, 1);
        wr_rst = 1; rd_rst = 1;
        repeat (2) @(negedge wr_clk);
        wr_rst = 0; rd_rst = 0;
        repeat (3) @(negedge wr_clk);
        chk(!rd_valid && !wr_full, "R1 reset discards", {wr_full, rd_valid}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule